// File: doc/BRIEF.md
# Periodic Battery Monitor Sequencer

This block wakes an external 8-bit serial analog-to-digital converter at a fixed interval, reads one battery-voltage code from it and decides whether the battery is low. All timing comes from a one-millisecond tick input. For each sample, the converter's active-low supply enable is pulled low for a fixed window of ticks. After a settling delay inside that window, the converter is selected. The block then generates its own serial clock and shifts the result in, most significant bit first.

A completed result at or below a fixed code (217, hex D9) sets a sticky low-battery flag. In the same cycle, the block drops its monitor-enable output, and no further sample windows start until reset. The window closes on schedule whether or not the read has finished. A read that is cut off by the window end is thrown away. A synchronous reset clears the flag, re-enables monitoring and opens the first window at once.

Top module: `batmon_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, batt_low is 0, mon_enable is 1, adc_pwr_n is 0 (a window is open), adc_sel_n is 1 and adc_sclk is 0.
- R2: In each window, adc_pwr_n stays low for exactly WINDOW_TICKS ticks. It returns high in the cycle after the WINDOW_TICKS-th tick counted after the window opened, and it is high outside windows.
- R3: adc_sel_n goes low in the cycle after the SETTLE_TICKS-th tick of a window and goes high together with adc_pwr_n at the window end. It is never low while adc_pwr_n is high.
- R4: adc_sclk toggles only while adc_sel_n is low. The first rise comes SCLK_HALF clocks after selection, and each high phase and each low phase lasts SCLK_HALF clocks. Exactly DATA_W rising edges are produced, after which the clock rests low. adc_dout is sampled at each rising edge, most significant bit first.
- R5: When the DATA_W-th bit is taken, batt_low becomes 1 in that same cycle if the assembled code is less than or equal to LOW_CODE (217). A code above LOW_CODE, including 218, leaves batt_low at 0.
- R6: Once batt_low is 1, it and mon_enable (then 0) hold until reset. The current window runs to its end, and adc_pwr_n never goes low again before reset.
- R7: Windows open every PERIOD_TICKS ticks. The period counter restarts when a window opens, and the opening falls on the PERIOD_TICKS-th tick after the previous opening.
- R8: If the window ends before all DATA_W bits have been taken, the partial result is discarded and batt_low is unchanged. adc_sclk is low once adc_sel_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_pwr_n | output | 1 | Converter supply enable, active low |
| adc_sel_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| batt_low | output | 1 | Sticky low-battery flag |
| mon_enable | output | 1 | High while periodic monitoring may continue |

## Verification
The bench builds the block with a 20-tick period, an 8-tick window, a 4-tick settle delay and a serial half period of 2 clocks. With these values a full period lasts a few hundred clocks, so many windows, the stop after a low reading and a second reset all fit in a short run. The half period of 2 exercises the clock divider rather than its one-clock variant. The bench also shortens the tick spacing to 3 clocks for one stretch. This makes the read phase of a window shorter than one full serial transfer, which brings the discarded-read case within reach.

// File: rtl/batmon_pkg.sv
package batmon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_READ   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   low;
        logic   mon;
    } ctl_t;

endpackage

// File: rtl/batmon_period.sv
module batmon_period #(
    parameter int PERIOD_TICKS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic wrap_o
);
    localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } per_t;

    per_t per_d, per_q;

    always_comb begin
        per_d  = per_q;
        wrap_o = tick && (per_q.cnt == LAST);
        if (tick) begin
            per_d.cnt = wrap_o ? '0 : per_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) per_q <= '0;
        else     per_q <= per_d;
    end
endmodule

// File: rtl/batmon_window.sv
module batmon_window #(
    parameter int WINDOW_TICKS = 8,
    parameter int SETTLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active_i,
    output logic settle_o,
    output logic end_o
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);
    localparam logic [CW-1:0] WIN_LAST    = CW'(WINDOW_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d    = win_q;
        settle_o = active_i && tick && (win_q.cnt == SETTLE_LAST);
        end_o    = active_i && tick && (win_q.cnt == WIN_LAST);
        if (!active_i) begin
            win_d.cnt = '0;
        end else if (tick) begin
            win_d.cnt = win_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end
endmodule

// File: rtl/batmon_shift.sv
module batmon_shift #(
    parameter int DATA_W    = 8,
    parameter int SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              sdi_i,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int NW = $clog2(DATA_W + 1);
    localparam logic [NW-1:0] NBITS   = NW'(DATA_W);
    localparam logic [NW-1:0] LASTBIT = NW'(DATA_W - 1);

    typedef struct packed {
        logic              sclk;
        logic [NW-1:0]     nbits;
        logic [DATA_W-1:0] sh;
    } shf_t;

    shf_t s_d, s_q;
    logic busy;
    logic half_done;
    logic toggle;
    logic capture;

    assign busy = (s_q.nbits < NBITS) || s_q.sclk;

    generate
        if (SCLK_HALF == 1) begin : g_nodiv
            assign half_done = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(SCLK_HALF);
            localparam logic [DW-1:0] DLAST = DW'(SCLK_HALF - 1);
            logic [DW-1:0] div_d, div_q;

            always_comb begin
                half_done = (div_q == DLAST);
                if (!run_i || !busy || half_done) div_d = '0;
                else                              div_d = div_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) div_q <= '0;
                else     div_q <= div_d;
            end
        end
    endgenerate

    assign toggle  = run_i && busy && half_done;
    assign capture = toggle && !s_q.sclk;
    assign word_o  = {s_q.sh[DATA_W-2:0], sdi_i};
    assign done_o  = capture && (s_q.nbits == LASTBIT);
    assign sclk_o  = s_q.sclk;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (toggle) begin
            s_d.sclk = !s_q.sclk;
            if (capture) begin
                s_d.sh    = word_o;
                s_d.nbits = s_q.nbits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/batmon_seq.sv
module batmon_seq #(
    parameter int PERIOD_TICKS = 10000,
    parameter int WINDOW_TICKS = 8,
    parameter int SETTLE_TICKS = 4,
    parameter int DATA_W       = 8,
    parameter int SCLK_HALF    = 4,
    parameter int LOW_CODE     = 217
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic adc_dout,
    output logic adc_pwr_n,
    output logic adc_sel_n,
    output logic adc_sclk,
    output logic batt_low,
    output logic mon_enable
);
    import batmon_pkg::*;

    localparam logic [DATA_W-1:0] LOW_WORD = DATA_W'(LOW_CODE);

    ctl_t c_d, c_q;
    logic wrap;
    logic settle_hit;
    logic end_hit;
    logic active;
    logic run;
    logic done;
    logic [DATA_W-1:0] word;

    assign active = (c_q.phase != PH_IDLE);

    batmon_period #(.PERIOD_TICKS(PERIOD_TICKS)) u_period (
        .clk    (clk),
        .rst    (rst),
        .tick   (ms_tick),
        .wrap_o (wrap)
    );

    batmon_window #(
        .WINDOW_TICKS (WINDOW_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .tick     (ms_tick),
        .active_i (active),
        .settle_o (settle_hit),
        .end_o    (end_hit)
    );

    batmon_shift #(
        .DATA_W    (DATA_W),
        .SCLK_HALF (SCLK_HALF)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .sdi_i  (adc_dout),
        .sclk_o (adc_sclk),
        .done_o (done),
        .word_o (word)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (wrap && c_q.mon) c_d.phase = PH_SETTLE;
            end
            PH_SETTLE: begin
                if (end_hit)         c_d.phase = PH_IDLE;
                else if (settle_hit) c_d.phase = PH_READ;
            end
            PH_READ: begin
                if (end_hit) c_d.phase = PH_IDLE;
            end
            default: c_d.phase = PH_IDLE;
        endcase
        if (done && (word <= LOW_WORD)) begin
            c_d.low = 1'b1;
            c_d.mon = 1'b0;
        end
    end

    // the shifter runs only while selection holds across this edge, so it
    // clears in the same cycle the window closes
    assign run = (c_q.phase == PH_READ) && (c_d.phase == PH_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.phase <= PH_SETTLE;
            c_q.low   <= 1'b0;
            c_q.mon   <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign adc_pwr_n  = (c_q.phase == PH_IDLE);
    assign adc_sel_n  = (c_q.phase != PH_READ);
    assign batt_low   = c_q.low;
    assign mon_enable = c_q.mon;
endmodule

// File: rtl/batmon_seq_chk.sv
module batmon_seq_chk (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic adc_pwr_n,
    input logic adc_sel_n,
    input logic adc_sclk,
    input logic batt_low,
    input logic mon_enable
);
    a_r3_sel_inside_power: assert property (@(posedge clk) disable iff (rst)
        !adc_sel_n |-> !adc_pwr_n);

    a_r3_select_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sel_n) |-> $past(ms_tick));

    a_r2_power_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_pwr_n) |-> $past(ms_tick));

    a_r4_sclk_needs_select: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_sel_n);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        batt_low |=> batt_low);

    a_r6_enable_stays_low: assert property (@(posedge clk) disable iff (rst)
        !mon_enable |=> !mon_enable);

    a_r6_enable_drops_with_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(batt_low) |-> $fell(mon_enable));

    a_r6_no_new_window: assert property (@(posedge clk) disable iff (rst)
        (!mon_enable && adc_pwr_n) |=> adc_pwr_n);
endmodule

bind batmon_seq batmon_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .adc_pwr_n  (adc_pwr_n),
    .adc_sel_n  (adc_sel_n),
    .adc_sclk   (adc_sclk),
    .batt_low   (batt_low),
    .mon_enable (mon_enable)
);

// File: tb/batmon_seq_test.sv
`timescale 1ns/100ps
module batmon_seq_test;
    localparam int P   = 20;
    localparam int W   = 8;
    localparam int S   = 4;
    localparam int DW  = 8;
    localparam int H   = 2;
    localparam int LOW = 217;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic adc_dout = 1'b0;
    logic adc_pwr_n, adc_sel_n, adc_sclk, batt_low, mon_enable;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int tick_gap = 40;
    int gap_cnt = 0;
    int sample_val = 8'hE5;
    int exp_flag = 0;
    int windows = 0;
    int falls = 0;
    int tick_cnt = 0;
    bit prev_pwr_n = 1'b0;
    bit prev_sel_n = 1'b1;
    bit prev_sclk = 1'b0;
    bit last_rst = 1'b1;
    int sh = 0;

    // reference model state
    int m_state = 1, m_win = 0, m_per = 0, m_div = 0, m_cnt = 0, m_data = 0;
    bit m_sclk = 0, m_low = 0, m_mon = 1;

    always #2.5 clk = ~clk;

    batmon_seq #(
        .PERIOD_TICKS (P),
        .WINDOW_TICKS (W),
        .SETTLE_TICKS (S),
        .DATA_W       (DW),
        .SCLK_HALF    (H),
        .LOW_CODE     (LOW)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .ms_tick    (ms_tick),
        .adc_dout   (adc_dout),
        .adc_pwr_n  (adc_pwr_n),
        .adc_sel_n  (adc_sel_n),
        .adc_sclk   (adc_sclk),
        .batt_low   (batt_low),
        .mon_enable (mon_enable)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phases 0 idle, 1 settle, 2 read
    always @(posedge clk) begin
        int ns;
        bit wrap;
        last_rst = rst;
        if (rst) begin
            m_state = 1; m_win = 0; m_per = 0; m_low = 0; m_mon = 1;
            m_div = 0; m_sclk = 0; m_cnt = 0; m_data = 0;
        end else begin
            ns = m_state;
            wrap = ms_tick && (m_per == P - 1);
            if (ms_tick) m_per = wrap ? 0 : m_per + 1;
            if (m_state == 0) begin
                if (wrap && m_mon) ns = 1;
            end else if (ms_tick) begin
                if (m_win == W - 1) ns = 0;
                else if (m_state == 1 && m_win == S - 1) ns = 2;
            end
            if (ns == 0) m_win = 0;
            else if (m_state != 0 && ms_tick) m_win = m_win + 1;
            if (m_state == 2 && ns == 2) begin
                if (m_cnt < DW || m_sclk) begin
                    if (m_div == H - 1) begin
                        m_div = 0;
                        if (!m_sclk) begin
                            m_data = ((m_data << 1) | int'(adc_dout)) & 8'hFF;
                            m_cnt++;
                            if (m_cnt == DW && m_data <= LOW) begin
                                m_low = 1; m_mon = 0;
                            end
                        end
                        m_sclk = !m_sclk;
                    end else begin
                        m_div++;
                    end
                end
            end else begin
                m_div = 0; m_sclk = 0; m_cnt = 0; m_data = 0;
            end
            m_state = ns;
        end
    end

    // per-cycle compare, window checks, converter model, tick source
    always @(negedge clk) begin
        if (!finished) begin
            chk(adc_pwr_n == (m_state == 0), "R2 pwr_n", int'(adc_pwr_n), int'(m_state == 0));
            chk(adc_sel_n == (m_state != 2), "R3 sel_n", int'(adc_sel_n), int'(m_state != 2));
            chk(adc_sclk == m_sclk, "R4 sclk", int'(adc_sclk), int'(m_sclk));
            chk(batt_low == m_low, "R5 batt_low", int'(batt_low), int'(m_low));
            chk(mon_enable == m_mon, "R6 mon_enable", int'(mon_enable), int'(m_mon));
        end
        if (last_rst) begin
            tick_cnt = 0;
        end else begin
            if (ms_tick) tick_cnt++;
            if (prev_pwr_n && !adc_pwr_n) begin
                chk(tick_cnt == P, "R7 ticks between openings", tick_cnt, P);
                falls++;
                tick_cnt = 0;
            end
            if (!prev_pwr_n && adc_pwr_n) begin
                chk(tick_cnt == W, "R2 window ticks", tick_cnt, W);
                chk(batt_low == exp_flag[0], "R5/R8 flag at window end", int'(batt_low), exp_flag);
                chk(adc_sclk == 1'b0, "R8 sclk rests low", int'(adc_sclk), 0);
                windows++;
            end
        end
        // converter model: load on select, shift on serial clock fall
        if (!adc_sel_n && prev_sel_n) sh = sample_val;
        else if (prev_sclk && !adc_sclk) sh = (sh << 1) & 8'hFF;
        adc_dout = sh[7];
        prev_pwr_n = adc_pwr_n;
        prev_sel_n = adc_sel_n;
        prev_sclk = adc_sclk;
        if (gap_cnt >= tick_gap - 1) begin
            ms_tick = 1'b1; gap_cnt = 0;
        end else begin
            ms_tick = 1'b0; gap_cnt++;
        end
    end

    task automatic wait_windows(input int n);
        int target = windows + n;
        while (windows < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state, window already open
        chk(batt_low == 0 && mon_enable == 1, "R1 flag/enable in reset", {batt_low, mon_enable}, 1);
        chk(adc_pwr_n == 0 && adc_sel_n == 1 && adc_sclk == 0, "R1 converter pins in reset",
            {adc_pwr_n, adc_sel_n, adc_sclk}, 3'b010);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_pwr_n == 0 && mon_enable == 1, "R1 window opens after reset",
            {adc_pwr_n, mon_enable}, 1);
        wait_windows(1);                       // 0xE5 read: clear (R5)
        sample_val = 8'hDA; exp_flag = 0;      // one above threshold (R5)
        wait_windows(2);
        tick_gap = 3; sample_val = 8'h10; exp_flag = 0;  // truncated read (R8)
        wait_windows(3);
        tick_gap = 40; sample_val = 8'hD9; exp_flag = 1; // at threshold (R5)
        wait_windows(1);
        f0 = falls;
        repeat (3 * P * 40) @(negedge clk);
        chk(falls == f0, "R6 no window after low", falls, f0);
        chk(mon_enable == 0 && batt_low == 1, "R6 flag and enable held", {batt_low, mon_enable}, 2);
        sample_val = 8'h00; exp_flag = 1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(batt_low == 0 && mon_enable == 1 && adc_pwr_n == 0, "R1 second reset",
            {batt_low, mon_enable, adc_pwr_n}, 3'b010);
        rst = 1'b0;
        wait_windows(1);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule